// File: doc/BRIEF.md
# Supply Power-Up Sequencer With Timeouts

This block brings up a chain of supply regulators one at a time so that a depletion-mode power amplifier never sees drain voltage before its gate bias is in place. A host raises a start request. The block holds that request and combines it with the hot-swap controller's power-good. It then turns on each regulator rail in a fixed order. After each rail is enabled, the block waits for that rail's power-good within a timeout, then lets the rail settle for a fixed delay before enabling the next one. After the last monitored rail has settled, an arm output rises. The amplifier drain rail is enabled only when the arm output is high and a separately held drain request is present.

If the hot-swap supply drops, or a rail misses its power-good window, all enables drop together on the next clock edge. A fault flag is then held until reset or a new start request. A power-down request removes the rails in reverse order with the same settle delay, and the drain rail goes first. All timing windows are derived from a clock-rate parameter, so one design serves real millisecond windows and short simulation windows.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: A rising edge on `up_req_i` is held internally. The sequence runs only while that held request and `hs_pg_i` are both high. With `hs_pg_i` low, no enable rises, and the held request still starts the sequence once `hs_pg_i` rises.
- R2: Enables rise strictly in the order `rail_en_o[0]`, `rail_en_o[1]`, up to the top rail, then `arm_o`. A higher output is never high while a lower one is low.
- R3: Each rail's power-good must be sampled high within TO_CYC clock edges after its enable rises, where TO_CYC = CLK_MHZ*PG_TIMEOUT_US. Otherwise the fault flag rises.
- R4: The next enable rises exactly ST_CYC clock edges after the edge that sampled the current rail's power-good, where ST_CYC = CLK_MHZ*SETTLE_US.
- R5: `pa_en_o` is high only when `arm_o` is high and a drain request (a held rising edge on `pa_req_i`) is present. A drain request made before the sequence completes is kept and takes effect when `arm_o` rises.
- R6: `status_o` bit 0 is the sequence enable (held start request AND `hs_pg_i`). Bit 1 is sequence complete (`done_o`). Bit 2 is the held drain request. Bit 3 is `pa_pg_i`.
- R7: A hot-swap power-good loss while any enable is high, or a power-good timeout, clears every enable and both held requests on the next edge. `fault_o` then stays high until a new start request, and a new start request restarts the sequence.
- R8: A rising edge on `down_req_i` clears both held requests, so `pa_en_o` falls on the next edge. `arm_o` falls ST_CYC+1 edges later. Each lower rail then falls ST_CYC edges after the one above it, and the block returns to idle.
- R9: During and after reset, all enables, `done_o`, `fault_o` and `status_o` bits 0 to 2 are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hs_pg_i | input | 1 | Hot-swap power-good |
| up_req_i | input | 1 | Start request, rising-edge held |
| down_req_i | input | 1 | Power-down request, rising edge |
| pa_req_i | input | 1 | Drain rail request, rising-edge held |
| rail_pg_i | input | NUM_RAILS | Per-rail power-good |
| pa_pg_i | input | 1 | Drain rail power-good, status only |
| rail_en_o | output | NUM_RAILS | Per-rail enables |
| arm_o | output | 1 | Final-stage arm output |
| pa_en_o | output | 1 | Drain rail enable |
| done_o | output | 1 | Sequence complete |
| fault_o | output | 1 | Held fault flag |
| status_o | output | 4 | Readback bits, see R6 |

## Verification
The assertions check the following on every cycle: the enables stay ordered, no first enable rises without the sequence enable, a fault leaves nothing enabled, a hot-swap loss clears the enables on the next edge, an expired power-good window produces the fault, and the drain enable is never high before completion. Only the bench scenarios can show the exact edge counts. These are the timeout boundary (one cycle inside and one cycle outside the window), the settle delay, and the staged reverse shutdown. The bench scenarios also show that an early drain request or a start request made while the hot-swap supply is low is kept, and that a new start request clears a held fault.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_PG, S_SETTLE, S_DONE, S_DOWN, S_FAULT
  } seq_state_e;
endpackage

// File: rtl/pwrseq_edge_latch.sv
module pwrseq_edge_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic clr_i,
  output logic q_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      q_o    <= 1'b0;
    end else begin
      prev_q <= req_i;
      if (clr_i)                q_o <= 1'b0;
      else if (req_i && !prev_q) q_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pwrseq_core.sv
module pwrseq_core
  import pwrseq_pkg::*;
#(
  parameter int NUM_RAILS = 3,
  parameter int TO_CYC    = 20,
  parameter int ST_CYC    = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 seq_en_i,
  input  logic                 hs_pg_i,
  input  logic [NUM_RAILS-1:0] rail_pg_i,
  output logic [NUM_RAILS:0]   en_o,
  output logic                 done_o,
  output logic                 fault_o,
  output logic                 fault_evt_o
);
  localparam int MAXC = (TO_CYC > ST_CYC) ? TO_CYC : ST_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int IW   = $clog2(NUM_RAILS + 1);
  localparam logic [IW-1:0] LAST = IW'(NUM_RAILS - 1);

  seq_state_e          state_q, state_d;
  logic [NUM_RAILS:0]  en_q, en_d;   // thermometer, bit NUM_RAILS = arm
  logic [IW-1:0]       idx_q, idx_d;
  logic                ld, expired, active;
  logic [CW-1:0]       ld_val;

  pwrseq_timer #(.W(CW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld), .val_i(ld_val),
    .expired_o(expired)
  );

  assign active = (state_q == S_WAIT_PG) || (state_q == S_SETTLE) ||
                  (state_q == S_DONE);

  always_comb begin
    state_d = state_q;
    en_d    = en_q;
    idx_d   = idx_q;
    ld      = 1'b0;
    ld_val  = '0;
    if (state_q != S_IDLE && state_q != S_FAULT && !hs_pg_i) begin
      state_d = S_FAULT;
    end else if (active && !seq_en_i) begin
      state_d = S_DOWN;
      ld      = 1'b1;
      ld_val  = CW'(ST_CYC - 1);
    end else begin
      unique case (state_q)
        S_IDLE, S_FAULT: if (seq_en_i) begin
          state_d = S_WAIT_PG;
          en_d    = '0;
          en_d[0] = 1'b1;
          idx_d   = '0;
          ld      = 1'b1;
          ld_val  = CW'(TO_CYC - 1);
        end
        S_WAIT_PG: begin
          if (rail_pg_i[idx_q]) begin
            state_d = S_SETTLE;
            ld      = 1'b1;
            ld_val  = CW'(ST_CYC - 1);
          end else if (expired) begin
            state_d = S_FAULT;
          end
        end
        S_SETTLE: if (expired) begin
          en_d = {en_q[NUM_RAILS-1:0], 1'b1};
          if (idx_q == LAST) begin
            state_d = S_DONE;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = S_WAIT_PG;
            ld      = 1'b1;
            ld_val  = CW'(TO_CYC - 1);
          end
        end
        S_DONE: ;
        S_DOWN: if (expired) begin
          en_d = en_q >> 1;
          if (!en_q[1]) state_d = S_IDLE;
          else begin
            ld     = 1'b1;
            ld_val = CW'(ST_CYC - 1);
          end
        end
        default: state_d = S_FAULT;
      endcase
    end
    if (state_d == S_FAULT) en_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      en_q    <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
      idx_q   <= idx_d;
    end
  end

  assign en_o        = en_q;
  assign done_o      = (state_q == S_DONE);
  assign fault_o     = (state_q == S_FAULT);
  assign fault_evt_o = (state_d == S_FAULT) && (state_q != S_FAULT);

  p_start_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q[0]) |-> $past(seq_en_i));

  for (genvar i = 1; i <= NUM_RAILS; i++) begin : g_order
    p_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_q[i] |-> en_q[i-1]);
  end

  p_timeout_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT_PG && hs_pg_i && seq_en_i && !rail_pg_i[idx_q] && expired)
    |=> fault_o);

  p_fault_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (en_q == '0));

  p_hs_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hs_pg_i && en_q != '0) |=> (en_q == '0));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int NUM_RAILS     = 3,
  parameter int CLK_MHZ       = 100,
  parameter int PG_TIMEOUT_US = 47000,
  parameter int SETTLE_US     = 2200
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hs_pg_i,
  input  logic                 up_req_i,
  input  logic                 down_req_i,
  input  logic                 pa_req_i,
  input  logic [NUM_RAILS-1:0] rail_pg_i,
  input  logic                 pa_pg_i,
  output logic [NUM_RAILS-1:0] rail_en_o,
  output logic                 arm_o,
  output logic                 pa_en_o,
  output logic                 done_o,
  output logic                 fault_o,
  output logic [3:0]           status_o
);
  localparam int TO_CYC = CLK_MHZ * PG_TIMEOUT_US;
  localparam int ST_CYC = CLK_MHZ * SETTLE_US;

  logic dn_prev_q, dn_rise, fault_evt, req_clr;
  logic up_q, pa_q, seq_en;
  logic [NUM_RAILS:0] en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dn_prev_q <= 1'b0;
    else         dn_prev_q <= down_req_i;
  end

  assign dn_rise = down_req_i && !dn_prev_q;
  assign req_clr = dn_rise || fault_evt;

  pwrseq_edge_latch u_up_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(up_req_i), .clr_i(req_clr), .q_o(up_q)
  );

  pwrseq_edge_latch u_pa_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(pa_req_i), .clr_i(req_clr), .q_o(pa_q)
  );

  assign seq_en = up_q && hs_pg_i;

  pwrseq_core #(.NUM_RAILS(NUM_RAILS), .TO_CYC(TO_CYC), .ST_CYC(ST_CYC)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .seq_en_i(seq_en), .hs_pg_i(hs_pg_i),
    .rail_pg_i(rail_pg_i), .en_o(en), .done_o(done_o), .fault_o(fault_o),
    .fault_evt_o(fault_evt)
  );

  assign rail_en_o = en[NUM_RAILS-1:0];
  assign arm_o     = en[NUM_RAILS];
  assign pa_en_o   = arm_o && pa_q;
  assign status_o  = {pa_pg_i, pa_q, done_o, seq_en};

  p_pa_after_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pa_en_o |-> done_o);
endmodule

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
  localparam int NR = 3;
  localparam int TO = 20;  // CLK_MHZ=1 scaling: 1 cycle per us
  localparam int ST = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hs_pg = 1'b0, up_req = 1'b0, dn_req = 1'b0, pa_req = 1'b0;
  logic [NR-1:0] rail_pg, rail_en;
  logic arm, pa_en, done, fault;
  logic [3:0] status;
  int unsigned dly [NR];
  int unsigned cnt [NR];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwr_seq_ctrl #(.NUM_RAILS(NR), .CLK_MHZ(1), .PG_TIMEOUT_US(TO), .SETTLE_US(ST)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .hs_pg_i(hs_pg), .up_req_i(up_req),
    .down_req_i(dn_req), .pa_req_i(pa_req), .rail_pg_i(rail_pg), .pa_pg_i(pa_en),
    .rail_en_o(rail_en), .arm_o(arm), .pa_en_o(pa_en), .done_o(done),
    .fault_o(fault), .status_o(status)
  );

  // regulator model: power-good dly[i] edges after enable
  always @(posedge clk) begin
    for (int i = 0; i < NR; i++)
      if (!rail_en[i]) cnt[i] <= 0;
      else if (cnt[i] < 1000) cnt[i] <= cnt[i] + 1;
  end
  always_comb
    for (int i = 0; i < NR; i++) rail_pg[i] = rail_en[i] && (cnt[i] >= dly[i]);

  // {d0, d1, d2, expect_fault}
  localparam int unsigned VEC [6][4] = '{
    '{0, 0, 0, 0}, '{3, 7, 2, 0}, '{19, 19, 19, 0},
    '{19, 20, 0, 1}, '{20, 0, 0, 1}, '{0, 0, 999, 1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; hs_pg = 1'b1; up_req = 0; dn_req = 0; pa_req = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which) 0: up_req = 1; 1: dn_req = 1; default: pa_req = 1; endcase
    @(negedge clk);
    up_req = 0; dn_req = 0; pa_req = 0;
  endtask

  initial begin
    for (int i = 0; i < NR; i++) dly[i] = 0;
    // R9 reset state
    repeat (2) @(negedge clk);
    chk("R9 enables in reset", {rail_en, arm, pa_en}, 0);
    chk("R9 flags in reset", {done, fault, status[2:0]}, 0);
    do_reset();
    chk("R9 after reset", {rail_en, arm, done, fault, status[2:0]}, 0);

    // table: R3 timeout boundary, R2 full bring-up
    for (int v = 0; v < 6; v++) begin
      do_reset();
      for (int i = 0; i < NR; i++) dly[i] = VEC[v][i];
      pulse(0);
      repeat (130) @(negedge clk);
      if (VEC[v][3] != 0) begin
        chk($sformatf("R3 vec%0d fault", v), fault, 1);
        chk($sformatf("R7 vec%0d all off", v), {rail_en, arm, pa_en}, 0);
      end else begin
        chk($sformatf("R3 vec%0d no fault", v), {fault, done}, 2'b01);
        chk($sformatf("R2 vec%0d all on", v), {rail_en, arm}, 4'b1111);
        chk($sformatf("R5 vec%0d no drain w/o request", v), pa_en, 0);
        chk($sformatf("R6 vec%0d status", v), status, 4'b0011);
      end
    end

    // R4 settle delay
    do_reset();
    dly[0] = 999; dly[1] = 999; dly[2] = 0;
    pulse(0);
    wait (rail_en[0]);
    repeat (2) @(negedge clk);
    dly[0] = 0;
    @(posedge clk);
    repeat (ST - 1) @(posedge clk);
    @(negedge clk);
    chk("R4 next rail still off", rail_en[1], 0);
    @(posedge clk); @(negedge clk);
    chk("R4 next rail on after settle", rail_en[1], 1);
    chk("R2 rail2 not before rail1", rail_en[2], 0);

    // R1 request held while hot-swap low
    do_reset();
    for (int i = 0; i < NR; i++) dly[i] = 2;
    hs_pg = 0;
    pulse(0);
    repeat (10) @(negedge clk);
    chk("R1 no enable with hs low", {rail_en, arm}, 0);
    chk("R6 seq enable bit low", status[0], 0);
    hs_pg = 1;
    repeat (100) @(negedge clk);
    chk("R1 held request runs", {done, rail_en, arm}, 5'b11111);

    // R5 early drain request
    do_reset();
    for (int i = 0; i < NR; i++) dly[i] = 3;
    pulse(0);
    pulse(2);
    repeat (8) @(negedge clk);
    chk("R5 early request not applied", pa_en, 0);
    chk("R6 drain request bit", status[2], 1);
    repeat (100) @(negedge clk);
    chk("R5 drain on after arm", pa_en, 1);
    chk("R6 full status", status, 4'b1111);

    // R8 reverse shutdown
    pulse(1);
    chk("R8 drain first", {pa_en, arm}, 2'b01);
    repeat (ST) @(posedge clk); @(negedge clk);
    chk("R8 arm held through settle", arm, 1);
    @(posedge clk); @(negedge clk);
    chk("R8 arm off", {arm, rail_en}, 4'b0111);
    repeat (ST) @(posedge clk); @(negedge clk);
    chk("R8 top rail off", rail_en, 3'b011);
    repeat (ST) @(posedge clk); @(negedge clk);
    chk("R8 mid rail off", rail_en, 3'b001);
    repeat (ST) @(posedge clk); @(negedge clk);
    chk("R8 all off idle", {rail_en, done, fault}, 0);

    // R7 hot-swap loss
    pulse(0);
    pulse(2);
    repeat (100) @(negedge clk);
    chk("R7 precondition up", {done, pa_en}, 2'b11);
    hs_pg = 0;
    @(negedge clk);
    chk("R7 all off next edge", {rail_en, arm, pa_en}, 0);
    chk("R7 fault raised", fault, 1);
    hs_pg = 1;
    repeat (6) @(negedge clk);
    chk("R7 fault held, no restart", {fault, rail_en, status[2]}, 5'b10000);
    pulse(0);
    repeat (2) @(negedge clk);
    chk("R7 new request clears fault", fault, 0);
    repeat (100) @(negedge clk);
    chk("R7 restarted sequence done", {done, arm}, 2'b11);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule